// File: doc/BRIEF.md
# Embedded-Sync Video Byte Stream Decoder

This block accepts digital component video in one of two physical shapes: a single 8-bit stream in which chroma and luma bytes alternate and line and field timing are carried by embedded timing reference codes, or two parallel 8-bit buses that carry luma and chroma side by side with separate sync pins. It produces one luma sample per pixel, the chroma sample that belongs with it (marked as blue- or red-difference), a pixel strobe, and horizontal sync, vertical blanking and field signals.

A two-bit mode input selects how timing is obtained. In the fully embedded mode the sync outputs come from the codes in the stream. In the two data-only modes the stream is still split into pixels, but the sync outputs follow external pins. In the parallel mode the stream decoder is bypassed. A sampling gate input, active low, lets a front end clocked at half the rate present one byte every second clock. Chroma that arrives in two's complement form can be converted to offset binary.

Top module: `vid656_decoder`

## Requirements
- R1: While reset is asserted and right after it, the pixel strobe, hsync, vertical blanking, field, luma, chroma and chroma-select outputs are all 0.
- R2: A timing code is recognised only as bytes FF, 00, 00 followed by a byte whose bit 7 is 1; in that last byte bit 6 is the field flag, bit 5 the blanking flag, and bit 4 is 1 for end-of-active-video and 0 for start-of-active-video. Bits 3..0 are ignored. An FF 00 00 sequence followed by a byte with bit 7 clear starts no active window.
- R3: After a start code the data bytes are taken in the order blue chroma, luma, red chroma, luma, repeating; the pixel strobe pulses for one clock after each luma byte is sampled, with luma_o equal to that byte, chroma_o equal to the preceding chroma byte, and chroma_is_cr 0 for blue and 1 for red.
- R4: Any sampled FF byte closes the active window and resets the byte order, so no pixel strobe appears between an end code and the next start code, and the first byte after a start code is always blue chroma.
- R5: In mode 11 the field and blanking outputs take the flags of an end code one clock after its last byte is sampled and hold between end codes; start codes leave them unchanged.
- R6: In mode 11 hsync rises one clock after an end code's last byte is sampled and stays high for HS_W clocks (default 8).
- R7: When chroma_twos is 1, every chroma output has its bit 7 inverted relative to the input byte; luma is never altered. When 0, chroma passes unchanged.
- R8: On clocks where smp_gate_n is 1, the inputs are not sampled: no strobe occurs, and neither the byte order, the active window nor any code detection advances.
- R9: In modes 01 and 10 hsync, blanking and field follow ext_hs, ext_vs and ext_fld with one sampled clock of delay, while the stream is still split into pixels as in R3.
- R10: In mode 00 each sampled clock with ext_hs low yields a strobe with luma_o equal to byte_in and chroma_o equal to aux_in (after R7); chroma_is_cr starts at 0 after a sampled clock with ext_hs high and toggles on each pixel. The sync outputs behave as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_gate_n | input | 1 | Sampling gate; inputs taken only when low |
| fmt_sel | input | 2 | 11 embedded sync, 01/10 data only, 00 parallel |
| chroma_twos | input | 1 | 1: incoming chroma is two's complement |
| byte_in | input | 8 | Multiplexed stream, or luma in parallel mode |
| aux_in | input | 8 | Chroma bus in parallel mode |
| ext_hs | input | 1 | External horizontal sync |
| ext_vs | input | 1 | External vertical blanking |
| ext_fld | input | 1 | External field flag |
| pix_vld | output | 1 | One-clock pixel strobe |
| luma_o | output | 8 | Luma sample |
| chroma_o | output | 8 | Chroma sample, offset binary |
| chroma_is_cr | output | 1 | 0 blue-difference, 1 red-difference |
| hsync_o | output | 1 | Horizontal sync |
| vblank_o | output | 1 | Vertical blanking |
| field_o | output | 1 | Field flag |

## Verification
The properties assume that the mode input changes only rarely, and they exempt the clock after a change; the bench switches modes only between scenarios, with no traffic in flight. They also assume that payload bytes inside an active window never equal FF, as the stream format reserves that value, and every stimulus stream uses payload values away from FF and 00. HS_W is taken to be at least 2, which the default satisfies.

// File: rtl/vid656_decoder.sv
module vid656_decoder #(
  parameter int HS_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_gate_n,
  input  logic [1:0] fmt_sel,
  input  logic       chroma_twos,
  input  logic [7:0] byte_in,
  input  logic [7:0] aux_in,
  input  logic       ext_hs,
  input  logic       ext_vs,
  input  logic       ext_fld,
  output logic       pix_vld,
  output logic [7:0] luma_o,
  output logic [7:0] chroma_o,
  output logic       chroma_is_cr,
  output logic       hsync_o,
  output logic       vblank_o,
  output logic       field_o
);
  localparam int CW = $clog2(HS_W + 1);

  logic [7:0]    h0, h1, h2;
  logic          live;
  logic [1:0]    ph;
  logic [7:0]    cpend;
  logic          cpend_cr;
  logic          ppar;
  logic [CW-1:0] hs_cnt;
  logic          ehs_r, vb_r, fl_r;

  wire smp = ~smp_gate_n;
  wire emb = (fmt_sel == 2'b11);
  wire par = (fmt_sel == 2'b00);
  wire trc = (h2 == 8'hFF) && (h1 == 8'h00) && (h0 == 8'h00) && byte_in[7];
  wire eav = trc & byte_in[4];
  wire sav = trc & ~byte_in[4];
  wire [7:0] cin = par ? aux_in : byte_in;
  wire [7:0] cconv = chroma_twos ? {~cin[7], cin[6:0]} : cin;

  assign hsync_o  = emb ? (hs_cnt != '0) : ehs_r;
  assign vblank_o = vb_r;
  assign field_o  = fl_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0 <= '0; h1 <= '0; h2 <= '0;
      live <= 1'b0; ph <= '0; cpend <= '0; cpend_cr <= 1'b0; ppar <= 1'b0;
      hs_cnt <= '0; ehs_r <= 1'b0; vb_r <= 1'b0; fl_r <= 1'b0;
      pix_vld <= 1'b0; luma_o <= '0; chroma_o <= '0; chroma_is_cr <= 1'b0;
    end else begin
      pix_vld <= 1'b0;
      if (hs_cnt != '0) hs_cnt <= hs_cnt - 1'b1;
      if (smp) begin
        h2 <= h1; h1 <= h0; h0 <= byte_in;
        if (!emb) begin
          ehs_r <= ext_hs; vb_r <= ext_vs; fl_r <= ext_fld;
        end
        if (par) begin
          if (ext_hs) ppar <= 1'b0;
          else begin
            pix_vld      <= 1'b1;
            luma_o       <= byte_in;
            chroma_o     <= cconv;
            chroma_is_cr <= ppar;
            ppar         <= ~ppar;
          end
        end else if (byte_in == 8'hFF) begin
          live <= 1'b0; ph <= '0;
        end else if (sav) begin
          live <= 1'b1; ph <= '0;
        end else if (eav) begin
          live <= 1'b0;
          if (emb) begin
            fl_r   <= byte_in[6];
            vb_r   <= byte_in[5];
            hs_cnt <= CW'(HS_W);
          end
        end else if (live) begin
          ph <= ph + 1'b1;
          if (!ph[0]) begin
            cpend    <= cconv;
            cpend_cr <= ph[1];
          end else begin
            pix_vld      <= 1'b1;
            luma_o       <= byte_in;
            chroma_o     <= cpend;
            chroma_is_cr <= cpend_cr;
          end
        end
      end
    end
  end
endmodule

module vid656_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_gate_n,
  input logic [1:0] fmt_sel,
  input logic       ext_hs,
  input logic       pix_vld,
  input logic       hsync_o,
  input logic       field_o,
  input logic       vblank_o
);
  AST_GATED_NO_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_gate_n) |-> !pix_vld); // R8

  AST_PIXEL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel != 2'b00 && pix_vld) |=> (!pix_vld || $past(fmt_sel) == 2'b00)); // R3

  AST_FLAGS_AT_END_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fmt_sel) == 2'b11 && $stable(fmt_sel) && (!$stable(field_o) || !$stable(vblank_o)))
    |-> hsync_o); // R5

  AST_HSYNC_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel == 2'b11 && $stable(fmt_sel) && $rose(hsync_o)) |=> (hsync_o || fmt_sel != 2'b11)); // R6

  AST_PARALLEL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fmt_sel) == 2'b00 && !$past(smp_gate_n) && !$past(ext_hs)) |-> pix_vld); // R10
endmodule

bind vid656_decoder vid656_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_gate_n(smp_gate_n), .fmt_sel(fmt_sel),
  .ext_hs(ext_hs), .pix_vld(pix_vld), .hsync_o(hsync_o),
  .field_o(field_o), .vblank_o(vblank_o)
);

// File: tb/vid656_decoder_tb.sv
module vid656_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_gate_n = 1'b0;
  logic [1:0] fmt_sel = 2'b11;
  logic       chroma_twos = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [7:0] aux_in = 8'h00;
  logic       ext_hs = 1'b0, ext_vs = 1'b0, ext_fld = 1'b0;
  logic       pix_vld, chroma_is_cr, hsync_o, vblank_o, field_o;
  logic [7:0] luma_o, chroma_o;
  int n_chk = 0, n_bad = 0;

  vid656_decoder #(.HS_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_gate_n(smp_gate_n), .fmt_sel(fmt_sel),
    .chroma_twos(chroma_twos), .byte_in(byte_in), .aux_in(aux_in),
    .ext_hs(ext_hs), .ext_vs(ext_vs), .ext_fld(ext_fld),
    .pix_vld(pix_vld), .luma_o(luma_o), .chroma_o(chroma_o),
    .chroma_is_cr(chroma_is_cr), .hsync_o(hsync_o),
    .vblank_o(vblank_o), .field_o(field_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    byte_in = b;
    @(negedge clk);
  endtask

  task automatic code(input logic [7:0] xy);
    put(8'hFF); put(8'h00); put(8'h00); put(xy);
  endtask

  task automatic t_reset;
    chk("R1 pix", pix_vld, 0); chk("R1 hs", hsync_o, 0);
    chk("R1 vb", vblank_o, 0); chk("R1 fld", field_o, 0);
    chk("R1 data", {luma_o, chroma_o, 7'd0, chroma_is_cr}, 0);
  endtask

  task automatic t_line;
    fmt_sel = 2'b11; chroma_twos = 1'b0;
    code(8'h80);
    put(8'h40); chk("R3 no strobe on Cb", pix_vld, 0);
    put(8'h50); chk("R3 strobe Y0", {pix_vld, luma_o, chroma_o, chroma_is_cr}, {1'b1, 8'h50, 8'h40, 1'b0});
    put(8'h60); chk("R3 no strobe on Cr", pix_vld, 0);
    put(8'h70); chk("R3 strobe Y1", {pix_vld, luma_o, chroma_o, chroma_is_cr}, {1'b1, 8'h70, 8'h60, 1'b1});
  endtask

  task automatic t_eav_hsync;
    int n;
    put(8'hFF); chk("R4 FF no strobe", pix_vld, 0);
    put(8'h00); put(8'h00); put(8'hF5);
    chk("R2 R5 flags from end code", {field_o, vblank_o}, 2'b11);
    chk("R6 hsync rises", hsync_o, 1);
    n = 1;
    for (int i = 0; i < 40 && hsync_o; i++) begin
      put(8'h10);
      if (hsync_o) n++;
      chk("R4 no strobe after end code", pix_vld, 0);
    end
    chk("R6 hsync width", n, 8);
    code(8'h80);
    chk("R5 start code keeps flags", {field_o, vblank_o}, 2'b11);
    put(8'h20); put(8'h30);
    code(8'h9A);
    chk("R5 flags cleared by end code", {field_o, vblank_o}, 2'b00);
  endtask

  task automatic t_phase_and_false_code;
    code(8'h80); put(8'h40); put(8'h50); put(8'h60);
    code(8'h80);
    put(8'h41); put(8'h51);
    chk("R4 order restarts at Cb", {pix_vld, chroma_o, chroma_is_cr}, {1'b1, 8'h41, 1'b0});
    put(8'h22); put(8'hFF); put(8'h33);
    put(8'h44); chk("R4 FF closes window", pix_vld, 0);
    put(8'hFF); put(8'h00); put(8'h00); put(8'h70);
    put(8'h22); put(8'h33);
    chk("R2 bit7 clear is no code", pix_vld, 0);
  endtask

  task automatic t_twos;
    chroma_twos = 1'b1;
    code(8'h80);
    put(8'h05); put(8'h90);
    chk("R7 Cb MSB inverted", {luma_o, chroma_o}, {8'h90, 8'h85});
    put(8'h85); put(8'h11);
    chk("R7 Cr MSB inverted", {luma_o, chroma_o}, {8'h11, 8'h05});
    chroma_twos = 1'b0;
    put(8'hFF);
  endtask

  task automatic t_gate;
    code(8'h80); put(8'h44);
    smp_gate_n = 1'b1;
    put(8'h66); chk("R8 gated no strobe", pix_vld, 0);
    put(8'hFF); put(8'h00); put(8'h00); put(8'hF0);
    chk("R8 gated code ignored", {pix_vld, field_o, vblank_o, hsync_o}, 4'b0000);
    smp_gate_n = 1'b0;
    put(8'h55);
    chk("R8 order kept across gate", {pix_vld, luma_o, chroma_o}, {1'b1, 8'h55, 8'h44});
    put(8'hFF);
  endtask

  task automatic t_ext;
    fmt_sel = 2'b01;
    ext_hs = 1'b1; ext_vs = 1'b1; ext_fld = 1'b1;
    put(8'h10);
    chk("R9 syncs follow pins", {hsync_o, vblank_o, field_o}, 3'b111);
    ext_hs = 1'b0; ext_vs = 1'b0;
    code(8'h90);
    chk("R9 end code does not drive flags", {hsync_o, vblank_o, field_o}, 3'b001);
    code(8'h80); put(8'h23); put(8'h34);
    chk("R9 stream still split", {pix_vld, luma_o, chroma_o}, {1'b1, 8'h34, 8'h23});
    put(8'hFF); ext_fld = 1'b0;
  endtask

  task automatic t_parallel;
    fmt_sel = 2'b00;
    ext_hs = 1'b1; aux_in = 8'h99;
    put(8'h01); chk("R10 no strobe in sync", pix_vld, 0);
    ext_hs = 1'b0; aux_in = 8'h22;
    put(8'h11);
    chk("R10 first pixel", {pix_vld, luma_o, chroma_o, chroma_is_cr}, {1'b1, 8'h11, 8'h22, 1'b0});
    aux_in = 8'h23;
    put(8'h12);
    chk("R10 second pixel", {pix_vld, luma_o, chroma_o, chroma_is_cr}, {1'b1, 8'h12, 8'h23, 1'b1});
    fmt_sel = 2'b11; put(8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_line;
        t_eav_hsync;
        t_phase_and_false_code;
        t_twos;
        t_gate;
        t_ext;
        t_parallel;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule